// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers interrupt requests from a set of peripherals and presents one interrupt line to the CPU. Each request input is edge-detected. A rising edge sets a sticky flag in a status register. Software picks the sources allowed to interrupt by loading a mask register. It acknowledges pending flags by writing the status register.

An acknowledge write ANDs the status with the written value and with the current mask. A zero in the written data clears that flag. Every flag that is not enabled in the mask is also dropped on each acknowledge, even where the written data bit is 1. Two optional configuration inputs can force the serial-port flag (bit 7) and the sound-unit flag (bit 9) to 1 just before the AND is applied. By convention the DMA engine's request is wired to source 3.

The CPU line is a flop that holds the OR of status AND mask, computed from the values those registers take at the same clock edge. A mask write that uncovers a pending flag therefore raises the line in the next cycle, with no new source event.

Top module: `irq_status_mask_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the status register, the mask register and `cpu_irq` all become 0.
- R2: A 0-to-1 change on `src_req[i]` sets status bit i at the next clock edge, whatever the mask holds. A request held high sets the bit only once, so after it is acknowledged it stays clear.
- R3: Without a status write, every status bit keeps its value, apart from new sets.
- R4: A write to offset 0x0 loads status with (status AND mask AND data), so a 0 data bit clears its flag.
- R5: An acknowledge write clears every status bit whose mask bit is 0, even if its data bit is 1.
- R6: During an acknowledge write, `force_serial` ORs 1 into status bit 7 and `force_sound` ORs 1 into bit 9, before the mask-and-data AND. Without a status write, the two inputs change nothing.
- R7: When a set and an acknowledge-clear hit the same bit in the same cycle, the bit ends up set.
- R8: A write to offset 0x4 loads the mask. `cpu_irq` equals the OR of (status AND mask) as they stand after each edge, so a mask write that exposes a pending flag raises `cpu_irq` in the next cycle.
- R9: `reg_rdata` shows the status at offset 0x0, the mask at offset 0x4 and 0 at any other offset. Reads change no state.
- R10: Writes to any offset other than 0x0 and 0x4 change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W (3) | Byte offset inside the register window |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_wdata | input | SRC_W (16) | Write data |
| reg_rdata | output | SRC_W (16) | Read data for `reg_addr` (combinational) |
| src_req | input | SRC_W (16) | Peripheral request lines, rising-edge detected |
| force_serial | input | 1 | Forces the serial flag on acknowledge writes |
| force_sound | input | 1 | Forces the sound flag on acknowledge writes |
| cpu_irq | output | 1 | Registered interrupt line to the CPU |

## Verification
The bench builds the block with its defaults: 16 sources, a 3-bit offset, the serial flag at bit 7 and the sound flag at bit 9. A 3-bit offset lets the bench reach the unused offsets 0x2 and 0x6 as well as the two registers. The fixed bit positions let it check that forced flags still pass through the mask-and-data AND. The directed scenarios include a set and a clear on the same bit in the same cycle, a request held high across an acknowledge, and a mask write that exposes a pending flag with no new event.

// File: rtl/ismc_pkg.sv
package ismc_pkg;

    localparam int unsigned OFS_STATUS = 0;
    localparam int unsigned OFS_MASK   = 4;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_MASK   = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic wr_status;
        logic wr_mask;
    } wr_strobe_t;

    function automatic reg_sel_e decode_offset(input int unsigned ofs);
        if (ofs == OFS_STATUS)    return SEL_STATUS;
        else if (ofs == OFS_MASK) return SEL_MASK;
        else                      return SEL_NONE;
    endfunction

    function automatic wr_strobe_t make_strobe(input logic we, input reg_sel_e sel);
        wr_strobe_t s;
        s.wr_status = we && (sel == SEL_STATUS);
        s.wr_mask   = we && (sel == SEL_MASK);
        return s;
    endfunction

endpackage

// File: rtl/ismc_edge.sv
module ismc_edge #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] rise_o
);

    logic [W-1:0] prev_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) prev_q[b] <= 1'b0;
            else     prev_q[b] <= level_i[b];
        end
        assign rise_o[b] = level_i[b] & ~prev_q[b];
    end

endmodule

// File: rtl/ismc_status.sv
module ismc_status #(
    parameter int unsigned W          = 16,
    parameter int unsigned SERIAL_BIT = 7,
    parameter int unsigned SOUND_BIT  = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ack_i,
    input  logic [W-1:0] ack_data_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] rise_i,
    input  logic         force_serial_i,
    input  logic         force_sound_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] status_next_o
);

    logic [W-1:0] status_q;
    logic [W-1:0] forced;
    logic [W-1:0] acked;

    always_comb begin
        forced             = '0;
        forced[SERIAL_BIT] = force_serial_i;
        forced[SOUND_BIT]  = force_sound_i;
        acked              = (status_q | forced) & mask_i & ack_data_i;
        // new sets take priority over the acknowledge clear
        status_next_o      = (ack_i ? acked : status_q) | rise_i;
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= status_next_o;
    end

    assign status_o = status_q;

    AST_STATUS_RESET: assert property (@(posedge clk)
        rst |=> (status_o == '0));  // R1
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|rise_i) |=> ((status_o & $past(rise_i)) == $past(rise_i)));  // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ack_i |=> ((status_o & ~($past(mask_i & ack_data_i) | $past(rise_i))) == '0));  // R5
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ack_i |=> (status_o == ($past(status_o) | $past(rise_i))));  // R3

endmodule

// File: rtl/irq_status_mask_ctrl.sv
module irq_status_mask_ctrl #(
    parameter int unsigned SRC_W      = 16,
    parameter int unsigned ADDR_W     = 3,
    parameter int unsigned SERIAL_BIT = 7,
    parameter int unsigned SOUND_BIT  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [SRC_W-1:0]  reg_wdata,
    output logic [SRC_W-1:0]  reg_rdata,
    input  logic [SRC_W-1:0]  src_req,
    input  logic              force_serial,
    input  logic              force_sound,
    output logic              cpu_irq
);
    import ismc_pkg::*;

    reg_sel_e         sel;
    wr_strobe_t       strobe;
    logic [SRC_W-1:0] rise;
    logic [SRC_W-1:0] status_q;
    logic [SRC_W-1:0] status_next;
    logic [SRC_W-1:0] mask_q;
    logic [SRC_W-1:0] mask_next;

    assign sel    = decode_offset(32'(reg_addr));
    assign strobe = make_strobe(reg_we, sel);

    ismc_edge #(.W(SRC_W)) i_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (src_req),
        .rise_o  (rise)
    );

    ismc_status #(
        .W          (SRC_W),
        .SERIAL_BIT (SERIAL_BIT),
        .SOUND_BIT  (SOUND_BIT)
    ) i_status (
        .clk            (clk),
        .rst            (rst),
        .ack_i          (strobe.wr_status),
        .ack_data_i     (reg_wdata),
        .mask_i         (mask_q),
        .rise_i         (rise),
        .force_serial_i (force_serial),
        .force_sound_i  (force_sound),
        .status_o       (status_q),
        .status_next_o  (status_next)
    );

    assign mask_next = strobe.wr_mask ? reg_wdata : mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            cpu_irq <= 1'b0;
        end else begin
            mask_q  <= mask_next;
            cpu_irq <= |(status_next & mask_next);
        end
    end

    always_comb begin
        unique case (sel)
            SEL_STATUS: reg_rdata = status_q;
            SEL_MASK:   reg_rdata = mask_q;
            default:    reg_rdata = '0;
        endcase
    end

    AST_MASK_RESET: assert property (@(posedge clk)
        rst |=> (mask_q == '0 && !cpu_irq));  // R1
    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
        cpu_irq == |(status_q & mask_q));  // R8
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        strobe.wr_mask |=> (mask_q == $past(reg_wdata)));  // R8
    AST_OTHER_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (reg_we && sel == SEL_NONE) |=> (mask_q == $past(mask_q)));  // R10

endmodule

// File: tb/test_irq_status_mask_ctrl.sv
module test_irq_status_mask_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_we = 1'b0;
    logic [W-1:0]  reg_wdata = '0;
    logic [W-1:0]  reg_rdata;
    logic [W-1:0]  src_req = '0;
    logic          force_serial = 1'b0;
    logic          force_sound = 1'b0;
    logic          cpu_irq;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_mask_ctrl i_irq_status_mask_ctrl (
        .clk          (clk),
        .rst          (rst),
        .reg_addr     (reg_addr),
        .reg_we       (reg_we),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .src_req      (src_req),
        .force_serial (force_serial),
        .force_sound  (force_sound),
        .cpu_irq      (cpu_irq)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=0x%04h exp=0x%04h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse(input logic [W-1:0] bits);
        @(negedge clk);
        src_req = src_req | bits;
        @(negedge clk);
        src_req = src_req & ~bits;
    endtask

    task automatic expect_state(input string tag, input logic [W-1:0] st, input logic irq);
        logic [W-1:0] v;
        rd(3'd0, v);
        check({tag, " status"}, v, st);
        check({tag, " cpu_irq"}, {15'd0, cpu_irq}, {15'd0, irq});
    endtask

    task automatic t_reset;
        logic [W-1:0] v;
        rd(3'd0, v); check("R1 status after reset", v, 16'h0000);
        rd(3'd4, v); check("R1 mask after reset", v, 16'h0000);
        check("R1 cpu_irq after reset", {15'd0, cpu_irq}, 16'h0000);
    endtask

    task automatic t_edge;
        wr(3'd4, 16'hFFFF);
        pulse(16'h0008);
        expect_state("R2 dma source 3 sets", 16'h0008, 1'b1);
        wr(3'd0, 16'h0000);
        expect_state("R4 clear all", 16'h0000, 1'b0);
        @(negedge clk); src_req[5] = 1'b1;
        @(negedge clk);
        expect_state("R2 held level sets once", 16'h0020, 1'b1);
        wr(3'd0, 16'hFFDF);
        repeat (3) @(negedge clk);
        expect_state("R2 held level no re-set", 16'h0000, 1'b0);
        src_req[5] = 1'b0;
    endtask

    task automatic t_sticky_ack;
        logic [W-1:0] v;
        pulse(16'h0028);
        repeat (5) @(negedge clk);
        expect_state("R3 flags stay pending", 16'h0028, 1'b1);
        rd(3'd0, v); rd(3'd0, v);
        check("R9 repeated read no side effect", v, 16'h0028);
        wr(3'd0, 16'hFFF7);
        expect_state("R4 zero bit clears only its flag", 16'h0020, 1'b1);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_unmasked;
        wr(3'd4, 16'h0001);
        pulse(16'h0011);
        expect_state("R2 set ignores mask", 16'h0011, 1'b1);
        wr(3'd0, 16'hFFFF);
        expect_state("R5 unmasked bit dropped on ack", 16'h0001, 1'b1);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_force;
        wr(3'd4, 16'hFFFF);
        @(negedge clk); force_serial = 1'b1; force_sound = 1'b1;
        repeat (2) @(negedge clk);
        expect_state("R6 force without write no effect", 16'h0000, 1'b0);
        force_sound = 1'b0;
        wr(3'd0, 16'hFFFF);
        expect_state("R6 serial bit 7 forced", 16'h0080, 1'b1);
        force_serial = 1'b0; force_sound = 1'b1;
        wr(3'd0, 16'hFD7F);
        expect_state("R6 forced sound bit 9 still ANDed with data", 16'h0000, 1'b0);
        wr(3'd4, 16'hFDFF);
        wr(3'd0, 16'hFFFF);
        expect_state("R6 forced sound bit 9 still ANDed with mask", 16'h0000, 1'b0);
        wr(3'd4, 16'hFFFF);
        wr(3'd0, 16'hFFFF);
        expect_state("R6 sound bit 9 forced", 16'h0200, 1'b1);
        force_sound = 1'b0;
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_set_wins;
        pulse(16'h0004);
        wr(3'd0, 16'h0000);
        @(negedge clk);
        reg_addr = 3'd0; reg_wdata = 16'h0000; reg_we = 1'b1; src_req[2] = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; src_req[2] = 1'b0;
        expect_state("R7 set beats same-cycle clear", 16'h0004, 1'b1);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_mask_irq;
        logic [W-1:0] v;
        wr(3'd4, 16'h0000);
        pulse(16'h0040);
        expect_state("R8 masked pending no irq", 16'h0040, 1'b0);
        wr(3'd4, 16'h0040);
        expect_state("R8 mask write raises irq", 16'h0040, 1'b1);
        rd(3'd4, v); check("R8 mask readback", v, 16'h0040);
        wr(3'd4, 16'h0000);
        expect_state("R8 mask clear drops irq, keeps status", 16'h0040, 1'b0);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_other_ofs;
        logic [W-1:0] v;
        wr(3'd4, 16'h00F0);
        pulse(16'h0010);
        wr(3'd2, 16'h0000);
        wr(3'd6, 16'h0000);
        expect_state("R10 other offsets keep status", 16'h0010, 1'b1);
        rd(3'd4, v); check("R10 other offsets keep mask", v, 16'h00F0);
        rd(3'd2, v); check("R9 unused offset reads zero", v, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_edge();
        t_sticky_ack();
        t_unmasked();
        t_force();
        t_set_wins();
        t_mask_irq();
        t_other_ofs();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        t_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule